// File: doc/BRIEF.md
# Inactivity-Based Serial Line Powerdown Controller

This block decides when the supply stage and the line drivers of a serial line interface are powered. It samples a group of transmit-side logic inputs and a group of receive-side inputs. It detects any change on any of those bits, and an idle timer measures how long none has appeared. After a programmable number of quiet clock cycles, the supply and drivers are turned off. The first later change wakes them again. While the supply ramps up after a wake, the line drivers are held off for a fixed number of cycles.

Two asynchronous control pins override the automatic behaviour. An active-low shutdown pin turns off everything except a non-inverting ring monitor path, and this pin wins over every other input. An active-high keep-on pin disables the idle timer. The sleep decision is sticky: once the interface is down, either by shutdown or by time-out, it stays down until a monitored input changes while the shutdown pin is released, or until keep-on rises. A fall of keep-on starts a complete idle period.

The control is a four-state machine. The states are SHUT (forced shutdown), DOZE (automatic sleep), RAMP (supply ramping, drivers held off) and RUN (fully active). The transitions are: any state to SHUT when the shutdown pin is low. SHUT to DOZE on release while the timer is still expired. SHUT or DOZE to RAMP on a wake request. RAMP to RUN when the ramp delay ends. RAMP or RUN to DOZE when the idle timer expires.

Top module: `pwr_idle_ctrl`

## Requirements
- R1: While the shutdown pin `off_req_n_i` is low, `supply_en_o`, `tx_en_o` and `rx_oe_o` are all 0 within 3 clock cycles, whatever the values of `stay_on_i` and of the monitored inputs.
- R2: While `off_req_n_i` and `stay_on_i` are both high, the interface never sleeps. `supply_en_o` is 1, and `tx_en_o` becomes 1 after the ramp delay and stays 1 for any length of inactivity.
- R3: With `off_req_n_i` high and `stay_on_i` low, `supply_en_o` and `tx_en_o` fall to 0 about IDLE_CYCLES cycles (plus a few cycles of synchronizer latency) after the last change on any monitored bit.
- R4: `rx_oe_o` is 1 in every state except forced shutdown, so it stays 1 during automatic sleep.
- R5: `ring_rx_o` always equals `ring_rx_i`, with no inversion, in every state including forced shutdown.
- R6: After a powerdown, either forced or automatic, the interface stays down until a change on a monitored input while `off_req_n_i` is high, or until `stay_on_i` is high. Releasing the shutdown pin alone does not wake it, and changes that occur during shutdown are ignored.
- R7: A falling edge of `stay_on_i` restarts the full idle period, so the interface stays awake for IDLE_CYCLES cycles even without traffic.
- R8: On every wake, `supply_en_o` rises at once and `tx_en_o` follows WAKE_CYCLES cycles later. `tx_en_o` is never 1 while `supply_en_o` is 0.
- R9: A rising or a falling change on any bit of `tx_lvl_i` or `rx_lvl_i` reloads the idle timer, so periodic activity keeps the interface awake.
- R10: After reset the block is in RUN (`supply_en_o`, `tx_en_o`, `rx_oe_o` all 1) with the idle count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_req_n_i | input | 1 | Active-low forced shutdown, asynchronous |
| stay_on_i | input | 1 | Active-high keep-on that disables the idle timer, asynchronous |
| tx_lvl_i | input | N_TX | Transmit-side logic inputs watched for activity |
| rx_lvl_i | input | N_RX | Receive-side sampled inputs watched for activity |
| ring_rx_i | input | 1 | Ring monitor receiver input |
| ring_rx_o | output | 1 | Non-inverted, always-enabled ring monitor output |
| supply_en_o | output | 1 | Supply stage and driver bias enable |
| tx_en_o | output | 1 | Line driver enable, delayed for supply ramp |
| rx_oe_o | output | 1 | Output enable of the inverting receivers |

## Verification
The bench goes after the stickiness of sleep. It releases shutdown with no traffic and expects the interface to stay down, and it toggles inputs during shutdown, which a design that latched those changes would turn into a false wake. It checks that receivers stay enabled in automatic sleep, where a design that merged the two powerdown kinds would cut them. It checks that a falling keep-on grants a full idle period, which a design that kept a stale count would shorten. It samples the driver enable inside and after the ramp window, so drivers enabled together with the supply, or never, are both caught.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;

    typedef enum logic [1:0] {
        PS_SHUT = 2'd0,
        PS_DOZE = 2'd1,
        PS_RAMP = 2'd2,
        PS_RUN  = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int          W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL;
                stab_q <= RST_VAL;
            end else begin
                meta_q <= d_i[b];
                stab_q <= meta_q;
            end
        end

        assign q_o[b] = stab_q;
    end

endmodule

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_i,
    output logic         any_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= s_i;
        end
    end

    always_comb begin
        diff  = s_i ^ prev_q;
        any_o = |diff;
    end

endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
    parameter int IDLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_n_s,
    input  logic on_s,
    input  logic act_i,
    output logic expired_o
);

    localparam int IW = $clog2(IDLE_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYCLES - 1);

    logic [IW-1:0] cnt_q;
    logic          exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (!off_n_s) begin
            // forced shutdown holds the timer expired
            cnt_q <= '0;
            exp_q <= 1'b1;
        end else if (on_s || act_i) begin
            // keep-on or activity reloads the period
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else if (!exp_q) begin
            if (cnt_q == IDLE_LAST) begin
                cnt_q <= '0;
                exp_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expired_o = exp_q;

endmodule

// File: rtl/pwr_ramp_timer.sv
module pwr_ramp_timer #(
    parameter int WAKE_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int RW = $clog2(WAKE_CYCLES + 1);
    localparam logic [RW-1:0] RAMP_LAST = RW'(WAKE_CYCLES - 1);

    logic [RW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == RAMP_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (!at_end) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && at_end;

endmodule

// File: rtl/pwr_idle_ctrl.sv
module pwr_idle_ctrl
    import pwr_idle_pkg::*;
#(
    parameter int N_TX        = 5,
    parameter int N_RX        = 3,
    parameter int IDLE_CYCLES = 30_000_000,
    parameter int WAKE_CYCLES = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            off_req_n_i,
    input  logic            stay_on_i,
    input  logic [N_TX-1:0] tx_lvl_i,
    input  logic [N_RX-1:0] rx_lvl_i,
    input  logic            ring_rx_i,
    output logic            ring_rx_o,
    output logic            supply_en_o,
    output logic            tx_en_o,
    output logic            rx_oe_o
);

    localparam int N_MON = N_TX + N_RX;

    logic             off_n_s;
    logic             on_s;
    logic [N_MON-1:0] mon_s;
    logic             act;
    logic             expired;
    logic             ramp_done;
    logic             awake_req;
    pwr_state_e       state_q;
    pwr_state_e       state_nxt;

    pwr_sync #(.W(1), .RST_VAL(1'b1)) u_off_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (off_req_n_i),
        .q_o  (off_n_s)
    );

    pwr_sync #(.W(1), .RST_VAL(1'b0)) u_on_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (stay_on_i),
        .q_o  (on_s)
    );

    pwr_sync #(.W(N_MON), .RST_VAL(1'b0)) u_mon_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({rx_lvl_i, tx_lvl_i}),
        .q_o  (mon_s)
    );

    pwr_edge_det #(.W(N_MON)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .s_i  (mon_s),
        .any_o(act)
    );

    pwr_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .off_n_s  (off_n_s),
        .on_s     (on_s),
        .act_i    (act),
        .expired_o(expired)
    );

    pwr_ramp_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (state_q == PS_RAMP),
        .done_o(ramp_done)
    );

    assign awake_req = on_s || !expired;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_RUN;
        end else begin
            state_q <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state_q;
        if (!off_n_s) begin
            state_nxt = PS_SHUT;
        end else begin
            unique case (state_q)
                PS_SHUT: state_nxt = awake_req ? PS_RAMP : PS_DOZE;
                PS_DOZE: state_nxt = awake_req ? PS_RAMP : PS_DOZE;
                PS_RAMP: begin
                    if (!awake_req) begin
                        state_nxt = PS_DOZE;
                    end else if (ramp_done) begin
                        state_nxt = PS_RUN;
                    end
                end
                PS_RUN:  state_nxt = awake_req ? PS_RUN : PS_DOZE;
                default: state_nxt = PS_SHUT;
            endcase
        end
    end

    // outputs
    always_comb begin
        supply_en_o = 1'b0;
        tx_en_o     = 1'b0;
        rx_oe_o     = 1'b0;
        unique case (state_q)
            PS_SHUT: begin
                supply_en_o = 1'b0;
                tx_en_o     = 1'b0;
                rx_oe_o     = 1'b0;
            end
            PS_DOZE: begin
                supply_en_o = 1'b0;
                tx_en_o     = 1'b0;
                rx_oe_o     = 1'b1;
            end
            PS_RAMP: begin
                supply_en_o = 1'b1;
                tx_en_o     = 1'b0;
                rx_oe_o     = 1'b1;
            end
            PS_RUN: begin
                supply_en_o = 1'b1;
                tx_en_o     = 1'b1;
                rx_oe_o     = 1'b1;
            end
            default: begin
                supply_en_o = 1'b0;
                tx_en_o     = 1'b0;
                rx_oe_o     = 1'b0;
            end
        endcase
    end

    assign ring_rx_o = ring_rx_i;

endmodule

// File: rtl/pwr_idle_ctrl_chk.sv
module pwr_idle_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic off_n_s,
    input logic on_s,
    input logic act,
    input logic expired,
    input logic supply_en_o,
    input logic tx_en_o,
    input logic rx_oe_o
);

    // R1
    shut_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !off_n_s |=> (!supply_en_o && !tx_en_o && !rx_oe_o));

    // R2
    keep_on_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_n_s && on_s) |=> supply_en_o);

    // R4
    rx_enabled_unless_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_n_s |=> rx_oe_o);

    // R6
    sleep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && off_n_s && !on_s && !act) |=> expired);

    // R7
    keep_on_fall_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(on_s) && off_n_s) |=> !expired);

    // R8
    drivers_need_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> supply_en_o);

    // R8
    ramp_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_en_o) |-> !tx_en_o);

endmodule

bind pwr_idle_ctrl pwr_idle_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .off_n_s    (off_n_s),
    .on_s       (on_s),
    .act        (act),
    .expired    (expired),
    .supply_en_o(supply_en_o),
    .tx_en_o    (tx_en_o),
    .rx_oe_o    (rx_oe_o)
);

// File: tb/sim_pwr_idle_ctrl.sv
module sim_pwr_idle_ctrl;

    localparam int N_TX  = 5;
    localparam int N_RX  = 3;
    localparam int IDLE  = 200;
    localparam int WAKE  = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            off_req_n = 1'b1;
    logic            stay_on = 1'b0;
    logic [N_TX-1:0] tx_lvl = '0;
    logic [N_RX-1:0] rx_lvl = '0;
    logic            ring_in = 1'b0;
    logic            ring_out;
    logic            supply_en;
    logic            tx_en;
    logic            rx_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwr_idle_ctrl #(
        .N_TX(N_TX), .N_RX(N_RX), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .off_req_n_i(off_req_n),
        .stay_on_i  (stay_on),
        .tx_lvl_i   (tx_lvl),
        .rx_lvl_i   (rx_lvl),
        .ring_rx_i  (ring_in),
        .ring_rx_o  (ring_out),
        .supply_en_o(supply_en),
        .tx_en_o    (tx_en),
        .rx_oe_o    (rx_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R10", "supply after reset", supply_en, 1'b1);
        check("R10", "drivers after reset", tx_en, 1'b1);
        check("R10", "receivers after reset", rx_oe, 1'b1);
    endtask

    task automatic t_activity_then_sleep();
        for (int i = 0; i < 4; i++) begin
            tx_lvl[0] = ~tx_lvl[0];
            tick(150);
            check("R9", "awake with periodic tx activity", supply_en, 1'b1);
        end
        tick(70);
        check("R3", "supply off after idle period", supply_en, 1'b0);
        check("R3", "drivers off after idle period", tx_en, 1'b0);
        check("R4", "receivers on in automatic sleep", rx_oe, 1'b1);
    endtask

    task automatic t_wake_on_rx();
        rx_lvl[N_RX-1] = 1'b1;
        tick(6);
        check("R9", "rx rising change wakes supply", supply_en, 1'b1);
        check("R8", "drivers held during ramp", tx_en, 1'b0);
        tick(10);
        check("R8", "drivers still held inside ramp", tx_en, 1'b0);
        tick(15);
        check("R8", "drivers on after ramp", tx_en, 1'b1);
        rx_lvl[N_RX-1] = 1'b0;
        tick(150);
        check("R9", "rx falling change reloads timer", supply_en, 1'b1);
        tick(70);
        check("R3", "sleep after falling change idle", supply_en, 1'b0);
    endtask

    task automatic t_force_off();
        off_req_n = 1'b0;
        tick(4);
        check("R1", "supply off in shutdown", supply_en, 1'b0);
        check("R1", "drivers off in shutdown", tx_en, 1'b0);
        check("R1", "receivers off in shutdown", rx_oe, 1'b0);
        stay_on = 1'b1;
        tx_lvl[1] = ~tx_lvl[1];
        tick(6);
        check("R1", "shutdown wins over keep-on", supply_en, 1'b0);
        check("R1", "receivers off despite activity", rx_oe, 1'b0);
        stay_on = 1'b0;
        tick(4);
        off_req_n = 1'b1;
        tick(10);
        check("R6", "release alone does not wake", supply_en, 1'b0);
        check("R4", "receivers back after release", rx_oe, 1'b1);
        rx_lvl[0] = ~rx_lvl[0];
        tick(6);
        check("R6", "change after release wakes", supply_en, 1'b1);
        tick(30);
        check("R8", "drivers on after ramp from shutdown", tx_en, 1'b1);
    endtask

    task automatic t_keep_on();
        tick(220);
        check("R3", "asleep before keep-on", supply_en, 1'b0);
        stay_on = 1'b1;
        tick(6);
        check("R2", "keep-on wakes supply", supply_en, 1'b1);
        check("R8", "drivers held after keep-on wake", tx_en, 1'b0);
        tick(30);
        check("R2", "drivers on under keep-on", tx_en, 1'b1);
        tick(400);
        check("R2", "no sleep under keep-on", tx_en, 1'b1);
        stay_on = 1'b0;
        tick(150);
        check("R7", "awake within full period after keep-on fall", supply_en, 1'b1);
        tick(70);
        check("R7", "sleep after full period", supply_en, 1'b0);
    endtask

    task automatic t_monitor();
        ring_in = 1'b1;
        tick(1);
        check("R5", "ring high in sleep", ring_out, 1'b1);
        off_req_n = 1'b0;
        ring_in = 1'b0;
        tick(4);
        check("R5", "ring low in shutdown", ring_out, 1'b0);
        ring_in = 1'b1;
        tick(1);
        check("R5", "ring high in shutdown", ring_out, 1'b1);
        off_req_n = 1'b1;
        tick(10);
        check("R5", "ring path does not wake", supply_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_activity_then_sleep();
        t_wake_on_rx();
        t_force_off();
        t_keep_on();
        t_monitor();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule